// File: doc/BRIEF.md
# Single-Level Page Table Translator

This block turns a virtual address into a physical address by fetching one page table entry from physical memory. A requester presents a virtual address with an access type. The block adds the virtual page number, scaled to 4-byte entries, to a table base register to form the entry address. It then issues a single read on a valid/ready memory port and waits for the returned word.

Pages and frames are both 1 KiB, so the low 10 address bits pass through unchanged. The physical side holds 32 frames. The entry carries a resident bit, three permission bits and a frame number. A non-resident entry produces a page fault. A resident entry whose permissions do not cover the access produces a protection fault. Otherwise the block places the frame number above the offset to form the physical address. The block holds one translation at a time. Software loads the table base through a write port.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd_valid`, `page_fault` and `prot_fault` are 0, and the table base is 0.
- R2: One cycle after a request is accepted, `mem_rd_valid` is 1 and `mem_rd_addr` equals (base + 4 × va[15:10]) modulo 2^15.
- R3: While `mem_rd_valid` is 1 and `mem_rd_ready` is 0, the read request and its address stay unchanged. The cycle after a ready handshake, `mem_rd_valid` is 0.
- R4: The entry holds resident in bit 0, read permission in bit 1, write permission in bit 2, execute permission in bit 3 and the frame number in bits 12:8. On success `pa` = {frame, va[9:0]}. Frame 7 with offset 0 gives 7168, and frame 31 with offset 0 gives 31744.
- R5: An entry with bit 0 clear gives `page_fault`=1, `prot_fault`=0 and `pa`=0.
- R6: `req_acc` encodes 0 = read, 1 = write, 2 = execute and 3 = reserved. A resident entry that lacks the bit the access needs, or any access with code 3, gives `prot_fault`=1, `page_fault`=0 and `pa`=0.
- R7: `done` is a single-cycle pulse in the cycle after `mem_rsp_valid` is seen for the outstanding read. The result is valid with it, and `busy` is 0 in that cycle.
- R8: A request presented while `busy` is 1 is ignored. It issues no read and does not alter the result of the translation in flight.
- R9: A base write applies to requests accepted afterwards. The entry address of a translation is fixed at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Table base write strobe |
| base_wdata | input | 15 | New table base byte address |
| req_valid | input | 1 | Translation request strobe |
| req_va | input | 16 | Virtual address |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| busy | output | 1 | A translation is in flight |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 15 | Entry byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Page table entry |
| done | output | 1 | Result pulse |
| pa | output | 15 | Physical address, 0 on any fault |
| page_fault | output | 1 | Entry not resident |
| prot_fault | output | 1 | Permissions do not cover the access |

## Verification
A wrong step in the walk sequencer shows at the memory port within one cycle of acceptance. A read that is missing, repeated or dropped early, or an address that is not the expected one, is visible there. A badly latched base, offset or access type stays hidden until `done`, and then shows as a wrong `pa` or a fault on the wrong line. Each of these is visible one cycle after the response. A state that fails to return to idle shows at the next request as a missing read.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W    = 16,
  parameter int OFF_W   = 10,
  parameter int PA_W    = 15,
  parameter int PTE_W   = 32,
  parameter int PFN_LSB = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_we,
  input  logic [PA_W-1:0]  base_wdata,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_va,
  input  logic [1:0]       req_acc,
  output logic             busy,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             done,
  output logic [PA_W-1:0]  pa,
  output logic             page_fault,
  output logic             prot_fault
);
  localparam int PFN_W = PA_W - OFF_W;
  localparam int VPN_W = VA_W - OFF_W;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;
  st_t st;

  logic [PA_W-1:0]  base_q;
  logic [OFF_W-1:0] off_q;
  logic [1:0]       acc_q;

  wire [VPN_W-1:0] vpn       = req_va[VA_W-1:OFF_W];
  wire [PA_W-1:0]  entry_adr = base_q + PA_W'({vpn, 2'b00});
  wire             resident  = mem_rsp_data[0];
  wire [PFN_W-1:0] frame     = mem_rsp_data[PFN_LSB +: PFN_W];
  wire unused_pte = ^{mem_rsp_data[PTE_W-1:PFN_LSB+PFN_W], mem_rsp_data[PFN_LSB-1:4]};

  logic allowed;
  always_comb begin
    case (acc_q)
      2'd0:    allowed = mem_rsp_data[1];
      2'd1:    allowed = mem_rsp_data[2];
      2'd2:    allowed = mem_rsp_data[3];
      default: allowed = 1'b0;
    endcase
  end

  assign busy         = (st != S_IDLE);
  assign mem_rd_valid = (st == S_REQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      base_q      <= '0;
      off_q       <= '0;
      acc_q       <= '0;
      mem_rd_addr <= '0;
      done        <= 1'b0;
      pa          <= '0;
      page_fault  <= 1'b0;
      prot_fault  <= 1'b0;
    end else begin
      done       <= 1'b0;
      pa         <= '0;
      page_fault <= 1'b0;
      prot_fault <= 1'b0;
      if (base_we) base_q <= base_wdata;
      case (st)
        S_IDLE: if (req_valid) begin
          mem_rd_addr <= entry_adr;
          off_q       <= req_va[OFF_W-1:0];
          acc_q       <= req_acc;
          st          <= S_REQ;
        end
        S_REQ: if (mem_rd_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          st   <= S_IDLE;
          done <= 1'b1;
          if (!resident)     page_fault <= 1'b1;
          else if (!allowed) prot_fault <= 1'b1;
          else               pa <= {frame, off_q};
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_read_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));
  p_read_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && mem_rd_ready) |=> !mem_rd_valid);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_fault_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(page_fault && prot_fault));
  p_fault_no_pa_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (page_fault || prot_fault) |-> (done && pa == '0));
  p_busy_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(mem_rd_addr));
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic clk = 0, rst_n = 0;
  logic base_we = 0;
  logic [14:0] base_wdata = '0;
  logic req_valid = 0;
  logic [15:0] req_va = '0;
  logic [1:0] req_acc = '0;
  logic busy, mem_rd_valid, mem_rd_ready = 0;
  logic [14:0] mem_rd_addr;
  logic mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = '0;
  logic done, page_fault, prot_fault;
  logic [14:0] pa;

  int tests = 0, fails = 0, cyc = 0;
  logic [14:0] base_m = '0;

  always #2.5 clk = ~clk;

  pt_walker dut (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog expired act=%0d exp<=50000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic set_base(input logic [14:0] b);
    @(negedge clk) base_we = 1; base_wdata = b;
    @(negedge clk) base_we = 0;
    base_m = b;
  endtask

  task automatic xlate(input logic [15:0] va, input logic [1:0] acc, input logic [31:0] pte,
                       input int rdw, input int rspw, input bit poke, input bit wrb,
                       input logic [14:0] nb);
    logic [14:0] ea, epa;
    logic need, epf, epr;
    ea = base_m + 15'(va[15:10] * 4);
    case (acc)
      2'd0: need = pte[1];
      2'd1: need = pte[2];
      2'd2: need = pte[3];
      default: need = 1'b0;
    endcase
    epf = !pte[0];
    epr = pte[0] && !need;
    epa = (epf || epr) ? 15'd0 : {pte[12:8], va[9:0]};
    @(negedge clk) req_valid = 1; req_va = va; req_acc = acc; mem_rd_ready = 0;
    @(negedge clk) req_valid = 0;
    chk("R2 rd_valid", mem_rd_valid, 1);
    chk("R2 rd_addr", mem_rd_addr, ea);
    chk("R2 busy", busy, 1);
    if (poke) begin req_valid = 1; req_va = ~va; req_acc = 2'd3; end
    for (int i = 0; i < rdw; i++) begin
      @(negedge clk);
      chk("R3 held valid", mem_rd_valid, 1);
      chk("R3 held addr", mem_rd_addr, ea);
    end
    mem_rd_ready = 1;
    @(negedge clk) mem_rd_ready = 0;
    chk("R3 single read", mem_rd_valid, 0);
    if (wrb) begin base_we = 1; base_wdata = nb; end
    for (int i = 0; i < rspw; i++) begin
      @(negedge clk) base_we = 0;
      chk("R7 no early done", done, 0);
      chk("R8 no second read", mem_rd_valid, 0);
    end
    req_valid = 0;
    mem_rsp_valid = 1; mem_rsp_data = pte;
    @(negedge clk) mem_rsp_valid = 0; base_we = 0;
    if (wrb) base_m = nb;
    chk("R7 done", done, 1);
    chk("R7 busy low", busy, 0);
    chk("R4 pa", pa, epa);
    chk("R5 page_fault", page_fault, epf);
    chk("R6 prot_fault", prot_fault, epr);
    @(negedge clk);
    chk("R7 done pulse", done, 0);
    chk("R8 idle after", mem_rd_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 rd_valid", mem_rd_valid, 0);
    chk("R1 faults", {page_fault, prot_fault}, 0);
    rst_n = 1;
    // R1 base 0 -> entry 12; R4 frame 7 -> 7168
    xlate(16'h0C00, 2'd0, 32'h0000_0703, 0, 0, 0, 0, 0);
    // R4 frame 31, offset 0 -> 31744; then full offset with write
    xlate(16'h1000, 2'd1, 32'h0000_1F05, 1, 2, 0, 0, 0);
    xlate(16'h13FF, 2'd1, 32'h0000_1F05, 0, 1, 0, 0, 0);
    // R5 non-resident
    xlate(16'h2155, 2'd0, 32'h0000_1F0E, 0, 0, 0, 0, 0);
    // R6 execute missing, reserved code, write missing
    xlate(16'h2421, 2'd2, 32'h0000_0307, 0, 0, 0, 0, 0);
    xlate(16'h2421, 2'd3, 32'h0000_030F, 0, 0, 0, 0, 0);
    xlate(16'h2421, 2'd1, 32'h0000_030B, 2, 0, 0, 0, 0);
    xlate(16'h2421, 2'd2, 32'h0000_0309, 0, 0, 0, 0, 0);
    // R9 base applies to next; R3 long stall; R8 poke while busy; base written mid-walk
    set_base(15'h1000);
    xlate(16'hFC12, 2'd0, 32'h0000_1103, 4, 3, 1, 1, 15'h2000);
    xlate(16'h0412, 2'd0, 32'h0000_0203, 0, 0, 0, 0, 0);
    // R2 modulo wrap of entry address
    set_base(15'h7FF0);
    xlate(16'h2000, 2'd0, 32'h0000_0A03, 0, 0, 0, 0, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule